// File: doc/BRIEF.md
# Associative Page Table Translator

This block maps a 20-bit virtual word address onto a 15-bit physical word address. It does not keep one table row per virtual page. It keeps one row per physical block, which gives 32 rows instead of 1024. Each row records which virtual page currently occupies that block. The page field of an incoming address is compared against every row at once. The row that matches supplies the 5-bit block number. That block number is joined above the untouched 10-bit word offset to form the physical address. When no row matches, a page-fault flag is raised instead.

Software or a miss handler fills the table through a load port. Each load writes one row, chosen by index, with a page number, a block number and a valid bit. Translation requests arrive with a valid strobe. Each answer is registered and appears one clock later.

Top module: `apt_translator`

## Requirements
- R1: While reset is asserted and right after it, rsp_valid, rsp_hit and rsp_fault are low and every table row is invalid, so any translation before the first load faults.
- R2: A request sampled with req_valid high at a clock edge produces rsp_valid high after that edge for one cycle; with req_valid low, rsp_valid is low in the following cycle.
- R3: On a hit, rsp_paddr[14:10] holds the matching row's block number and rsp_paddr[9:0] equals req_vaddr[9:0]; the page number is req_vaddr[19:10].
- R4: When no valid row holds the requested page number, rsp_fault is high and rsp_hit is low.
- R5: A row loaded with its valid bit low never matches, whatever page number it holds.
- R6: When several valid rows hold the same page number, the row with the lowest index supplies the block number.
- R7: A load written at a clock edge is seen by requests sampled at later edges; a request sampled at the same edge as the load uses the table as it stood before the load.
- R8: While rsp_valid is high exactly one of rsp_hit and rsp_fault is high; while it is low both are low.
- R9: Reloading a row replaces its previous mapping, so the old page number no longer hits through that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 20 | Virtual address: page in [19:10], offset in [9:0] |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 15 | Physical address: block in [14:10], offset in [9:0] |
| rsp_hit | output | 1 | A valid row matched |
| rsp_fault | output | 1 | No valid row matched |
| ld_en | input | 1 | Write one table row this cycle |
| ld_idx | input | 5 | Row index to write |
| ld_page | input | 10 | Virtual page number for the row |
| ld_block | input | 5 | Physical block number for the row |
| ld_valid | input | 1 | Valid bit for the row |

## Verification
Some properties are checked on every cycle. These are the one-cycle response timing, the exclusive hit/fault flags, offset pass-through, a fault whenever the search finds nothing, a single selected row, and the fact that a row loaded as invalid is cleared. Other behaviours appear only in the bench's scenarios. These are the block number actually returned, the lowest-index rule for duplicate pages, the ordering between a load and a request at the same edge, and the loss of an old mapping after a row is rewritten.

// File: rtl/apt_pkg.sv
package apt_pkg;
  parameter int unsigned APT_VA_W    = 20;
  parameter int unsigned APT_PA_W    = 15;
  parameter int unsigned APT_OFS_W   = 10;
  parameter int unsigned APT_ENTRIES = 32;
endpackage

// File: rtl/apt_entry_store.sv
module apt_entry_store #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned PAGE_W  = 10,
  parameter int unsigned BLK_W   = 5,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [IDX_W-1:0]              ld_idx,
  input  logic [PAGE_W-1:0]             ld_page,
  input  logic [BLK_W-1:0]              ld_block,
  input  logic                          ld_valid,
  output logic [ENTRIES-1:0]            tbl_valid,
  output logic [ENTRIES-1:0][PAGE_W-1:0] tbl_page,
  output logic [ENTRIES-1:0][BLK_W-1:0]  tbl_block
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic             wr_en;
    logic             valid_d;
    logic [PAGE_W-1:0] page_d;
    logic [BLK_W-1:0]  block_d;

    always_comb begin
      wr_en   = ld_en && (ld_idx == IDX_W'(g));
      valid_d = wr_en ? ld_valid : tbl_valid[g];
      page_d  = wr_en ? ld_page  : tbl_page[g];
      block_d = wr_en ? ld_block : tbl_block[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_valid[g] <= 1'b0;
      else        tbl_valid[g] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tbl_page[g]  <= page_d;
        tbl_block[g] <= block_d;
      end
    end
  end

  AST_INVALID_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_valid) |=> !tbl_valid[$past(ld_idx)]); // R5
endmodule

// File: rtl/apt_match.sv
module apt_match #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned PAGE_W  = 10,
  parameter int unsigned BLK_W   = 5
) (
  input  logic [ENTRIES-1:0]             tbl_valid,
  input  logic [ENTRIES-1:0][PAGE_W-1:0] tbl_page,
  input  logic [ENTRIES-1:0][BLK_W-1:0]  tbl_block,
  input  logic [PAGE_W-1:0]              key_page,
  output logic                           hit,
  output logic [BLK_W-1:0]               hit_block,
  output logic [ENTRIES-1:0]             sel_vec
);
  logic [ENTRIES-1:0] raw;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign raw[g] = tbl_valid[g] && (tbl_page[g] == key_page);
  end

  always_comb begin
    hit       = 1'b0;
    hit_block = '0;
    sel_vec   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (raw[i] && !hit) begin
        hit        = 1'b1;
        sel_vec[i] = 1'b1;
        hit_block  = tbl_block[i];
      end
    end
  end
endmodule

// File: rtl/apt_translator.sv
module apt_translator
  import apt_pkg::*;
#(
  parameter int unsigned VA_W    = APT_VA_W,
  parameter int unsigned PA_W    = APT_PA_W,
  parameter int unsigned OFS_W   = APT_OFS_W,
  parameter int unsigned ENTRIES = APT_ENTRIES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [VA_W-1:0]               req_vaddr,
  output logic                          rsp_valid,
  output logic [PA_W-1:0]               rsp_paddr,
  output logic                          rsp_hit,
  output logic                          rsp_fault,
  input  logic                          ld_en,
  input  logic [$clog2(ENTRIES)-1:0]    ld_idx,
  input  logic [VA_W-OFS_W-1:0]         ld_page,
  input  logic [PA_W-OFS_W-1:0]         ld_block,
  input  logic                          ld_valid
);
  localparam int unsigned PAGE_W = VA_W - OFS_W;
  localparam int unsigned BLK_W  = PA_W - OFS_W;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             tbl_valid;
  logic [ENTRIES-1:0][PAGE_W-1:0] tbl_page;
  logic [ENTRIES-1:0][BLK_W-1:0]  tbl_block;
  logic                           m_hit;
  logic [BLK_W-1:0]               m_block;
  logic [ENTRIES-1:0]             m_sel;

  apt_entry_store #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_page(ld_page), .ld_block(ld_block), .ld_valid(ld_valid),
    .tbl_valid(tbl_valid), .tbl_page(tbl_page), .tbl_block(tbl_block)
  );

  apt_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_match (
    .tbl_valid(tbl_valid), .tbl_page(tbl_page), .tbl_block(tbl_block),
    .key_page(req_vaddr[VA_W-1:OFS_W]),
    .hit(m_hit), .hit_block(m_block), .sel_vec(m_sel)
  );

  logic            valid_d, hit_d, fault_d;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && m_hit;
    fault_d = req_valid && !m_hit;
    paddr_d = req_valid ? {m_block, req_vaddr[OFS_W-1:0]} : rsp_paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_fault <= fault_d;
      rsp_paddr <= paddr_d;
    end
  end

  AST_RSP_AFTER_REQ:  assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE:       assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_OFFSET_PASS:    assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))); // R3
  AST_MISS_FAULTS:    assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (m_sel == '0)) |=> (rsp_fault && !rsp_hit)); // R4
  AST_ONE_ROW:        assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_sel)); // R6
  AST_FLAGS_EXCL:     assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault}) == 1)); // R8
  AST_FLAGS_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fault)); // R8
endmodule

// File: tb/tb_apt_translator.sv
`timescale 1ns/1ps
module tb_apt_translator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [19:0] req_vaddr;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic        rsp_hit;
  logic        rsp_fault;
  logic        ld_en;
  logic [4:0]  ld_idx;
  logic [9:0]  ld_page;
  logic [4:0]  ld_block;
  logic        ld_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  apt_translator dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_page(ld_page), .ld_block(ld_block), .ld_valid(ld_valid)
  );

  // vector fields: {vaddr[19:0], expect_hit, expect_paddr[14:0]}
  localparam logic [35:0] VEC [8] = '{
    {10'h005, 10'h2A5, 1'b1, 5'd3,  10'h2A5},  // R3, R6 (row 0 beats row 10)
    {10'h3FF, 10'h3FF, 1'b1, 5'd31, 10'h3FF},  // R3 top page
    {10'h000, 10'h000, 1'b1, 5'd16, 10'h000},  // R3 page zero
    {10'h123, 10'h001, 1'b1, 5'd9,  10'h001},  // R3
    {10'h200, 10'h155, 1'b1, 5'd1,  10'h155},  // R3 last row
    {10'h077, 10'h0AA, 1'b0, 5'd0,  10'h000},  // R5 invalid row
    {10'h3FE, 10'h000, 1'b0, 5'd0,  10'h000},  // R4
    {10'h006, 10'h2A5, 1'b0, 5'd0,  10'h000}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [4:0] i, input logic [9:0] p, input logic [4:0] b, input logic v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = i; ld_page = p; ld_block = b; ld_valid = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic xlate(input logic [19:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic hit, input logic [14:0] pa);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"},   32'(rsp_hit),   32'(hit));
    chk({tag, " fault"}, 32'(rsp_fault), 32'(!hit));
    if (hit) chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    ld_en = 1'b0; ld_idx = '0; ld_page = '0; ld_block = '0; ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1 rsp_hit in reset",   32'(rsp_hit),   32'd0);
    chk("R1 rsp_fault in reset", 32'(rsp_fault), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    xlate({10'h000, 10'h000});
    expect_rsp("R1 empty table", 1'b0, '0);
    @(negedge clk);
    chk("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R8 idle flags", 32'({rsp_hit, rsp_fault}), 32'd0);

    load(5'd0,  10'h005, 5'd3,  1'b1);
    load(5'd1,  10'h3FF, 5'd31, 1'b1);
    load(5'd2,  10'h000, 5'd16, 1'b1);
    load(5'd7,  10'h123, 5'd9,  1'b1);
    load(5'd31, 10'h200, 5'd1,  1'b1);
    load(5'd10, 10'h005, 5'd22, 1'b1);
    load(5'd4,  10'h077, 5'd5,  1'b0);

    for (int k = 0; k < 8; k++) begin
      xlate(VEC[k][35:16]);
      expect_rsp($sformatf("R3/R4 vector %0d", k), VEC[k][15], VEC[k][14:0]);
    end

    // R7: load and request at the same edge see the old table
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 5'd3; ld_page = 10'h050; ld_block = 5'd12; ld_valid = 1'b1;
    req_valid = 1'b1; req_vaddr = {10'h050, 10'h011};
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R7 same-edge load", 1'b0, '0);
    xlate({10'h050, 10'h011});
    expect_rsp("R7 after load", 1'b1, {5'd12, 10'h011});

    // R9: rewrite row 3
    load(5'd3, 10'h051, 5'd13, 1'b1);
    xlate({10'h050, 10'h011});
    expect_rsp("R9 old page gone", 1'b0, '0);
    xlate({10'h051, 10'h3C0});
    expect_rsp("R9 new page", 1'b1, {5'd13, 10'h3C0});

    // R6/R5: invalidating row 0 exposes duplicate in row 10
    load(5'd0, 10'h005, 5'd3, 1'b0);
    xlate({10'h005, 10'h001});
    expect_rsp("R6 next duplicate", 1'b1, {5'd22, 10'h001});
    load(5'd10, 10'h005, 5'd22, 1'b0);
    xlate({10'h005, 10'h001});
    expect_rsp("R5 all invalid", 1'b0, '0);

    // R2: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {10'h3FF, 10'h001};
    @(negedge clk);
    expect_rsp("R2 back-to-back first", 1'b1, {5'd31, 10'h001});
    req_vaddr = {10'h123, 10'h002};
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R2 back-to-back second", 1'b1, {5'd9, 10'h002});
    @(negedge clk);
    chk("R2 drop after burst", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule